// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Pin and Latch Read Views

This block is one 8-bit general-purpose I/O port on a small microcontroller register bus. It holds an output latch and a direction register. It drives an output value and an output enable for each bit to the pad logic. It brings the pad input levels in through a two-stage synchronizer.

The output latch can be reached at two bus addresses. The pin view returns the synchronized levels seen on the pads. The latch view returns the stored latch contents. Both addresses write the same latch.

Each bus transaction lasts one cycle. A transaction is a read, a full-byte write, or a single-bit set or clear. A bit set or clear is a read-modify-write. It takes the whole byte from the addressed view, changes the selected bit, and writes the result into the target register on the edge that ends the transaction. Software uses the latch view for bit operations on output bits. The pin view is used to read inputs. A bit operation at the pin view copies every lagging pad level into the latch.

Top module: `gpio_lat_port`

## Requirements
- R1: While reset is high, the latch is set to 0x00 and the direction register to 0xFF, so every pad driver is off. Afterwards pad_out reads 0x00, pad_oe reads 0x00, and a read of address 0 returns 0xFF.
- R2: pad_out always equals the latch. Bit i of pad_oe is 1 exactly when direction bit i is 0. A direction bit of 1 means input and a direction bit of 0 means output.
- R3: A read of address 1 (pin view) returns the pad_in value that was present two clock edges earlier. A change on pad_in applied after one edge is not visible after that edge, and becomes visible after the second edge.
- R4: A read of address 2 (latch view) returns the latch contents, whatever the pad levels are.
- R5: A full-byte write (op 1) to address 1 or address 2 loads bus_wdata into the latch on the edge that ends the transaction. The pad levels have no effect on the result.
- R6: A bit set (op 2) or bit clear (op 3) at address 2 changes only latch bit bus_bit. All other latch bits keep their values, even when the pads disagree with them.
- R7: A bit set or clear at address 1 writes into the latch the synchronized pin view with bit bus_bit forced to 1 or 0. Any other bit whose pad level differs from its latch value is overwritten with the pad level.
- R8: Address 0 holds the direction register. It accepts byte writes and bit set or clear, reads back its value, and never changes the latch.
- R9: Address 3 reads as 0x00. Writes to address 3 change neither the latch nor the direction register.
- R10: When bus_valid is low, the latch and the direction register keep their values, whatever the other bus inputs are. Reads (op 0) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Transaction strobe for this cycle |
| bus_addr | input | 2 | 0 direction, 1 pin view, 2 latch view, 3 unused |
| bus_op | input | 2 | 0 read, 1 byte write, 2 bit set, 3 bit clear |
| bus_bit | input | 3 | Bit index for set and clear |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Combinational read data for the addressed view |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Output value to the pads |
| pad_oe | output | 8 | Per-bit output driver enable |

## Verification
The hardest case to reach is a pad that lags its latch bit, which is what makes a bit operation at the pin view corrupt the other bits. The bench models the pad as a free input. Before a bit operation it holds pad_in on a value that differs from the latch, for example all zeros after the latch was loaded with a nonzero byte, for long enough to pass the synchronizer. It then runs the same kind of operation at both addresses and compares the whole latch byte, so that both the corruption at the pin view and the lack of corruption at the latch view are checked.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_PIN  = 2'd1,
        SEL_LAT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_SET = 2'd2,
        OP_CLR = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic     valid;
        reg_sel_e sel;
        bus_op_e  op;
    } bus_cmd_t;

    function automatic logic cmd_writes(bus_cmd_t c);
        return c.valid && (c.op != OP_RD);
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= async_in;
            else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bit_alu.sv
module gpio_bit_alu
    import gpio_pkg::*;
#(
    parameter int W  = 8,
    localparam int BW = (W > 1) ? $clog2(W) : 1
) (
    input  bus_op_e       op,
    input  logic [BW-1:0] bit_idx,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  rd_val,
    output logic [W-1:0]  new_val
);
    logic [W-1:0] mask;

    always_comb begin
        mask = W'(1) << bit_idx;
        unique case (op)
            OP_WR:   new_val = wdata;
            OP_SET:  new_val = rd_val | mask;
            OP_CLR:  new_val = rd_val & ~mask;
            default: new_val = rd_val;
        endcase
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_lat,
    input  logic         wr_dir,
    input  logic [W-1:0] new_val,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] dir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            dir_q <= '1;
        end else begin
            if (wr_lat) lat_q <= new_val;
            if (wr_dir) dir_q <= new_val;
        end
    end
endmodule

// File: rtl/gpio_lat_port.sv
module gpio_lat_port
    import gpio_pkg::*;
#(
    parameter int W = 8,
    localparam int BW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_valid,
    input  logic [1:0]    bus_addr,
    input  logic [1:0]    bus_op,
    input  logic [BW-1:0] bus_bit,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe
);
    bus_cmd_t     cmd;
    logic [W-1:0] pin_view, lat_q, dir_q, rd_val, new_val;
    logic         wr_lat, wr_dir;

    assign cmd = '{valid: bus_valid, sel: reg_sel_e'(bus_addr), op: bus_op_e'(bus_op)};

    gpio_pin_sync #(.W(W), .STAGES(2)) sync_i (
        .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(pin_view)
    );

    always_comb begin
        unique case (cmd.sel)
            SEL_DIR: rd_val = dir_q;
            SEL_PIN: rd_val = pin_view;
            SEL_LAT: rd_val = lat_q;
            default: rd_val = '0;
        endcase
    end

    gpio_bit_alu #(.W(W)) alu_i (
        .op(cmd.op), .bit_idx(bus_bit), .wdata(bus_wdata),
        .rd_val(rd_val), .new_val(new_val)
    );

    assign wr_lat = cmd_writes(cmd) && (cmd.sel == SEL_PIN || cmd.sel == SEL_LAT);
    assign wr_dir = cmd_writes(cmd) && (cmd.sel == SEL_DIR);

    gpio_regfile #(.W(W)) regs_i (
        .clk(clk), .rst(rst), .wr_lat(wr_lat), .wr_dir(wr_dir),
        .new_val(new_val), .lat_q(lat_q), .dir_q(dir_q)
    );

    assign bus_rdata = rd_val;
    assign pad_out   = lat_q;
    assign pad_oe    = ~dir_q;

    // Edges since reset, used only to gate the synchronizer latency check
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pad_out == '0 && pad_oe == '0));

    assert_pin_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (pin_view == $past(pad_in, 2)));

    assert_byte_write_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_op == OP_WR && (bus_addr == SEL_PIN || bus_addr == SEL_LAT))
        |=> (pad_out == $past(bus_wdata)));

    assert_alias_keeps_others_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr == SEL_LAT && (bus_op == OP_SET || bus_op == OP_CLR))
        |=> (((pad_out ^ $past(pad_out)) & ~(W'(1) << $past(bus_bit))) == '0));

    assert_port_target_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr == SEL_PIN && (bus_op == OP_SET || bus_op == OP_CLR))
        |=> (pad_out[$past(bus_bit)] == ($past(bus_op) == OP_SET)));

    assert_dir_no_latch_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr == SEL_DIR) |=> $stable(pad_out));

    assert_unused_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr == SEL_NONE) |=> ($stable(pad_out) && $stable(pad_oe)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!bus_valid || bus_op == OP_RD) |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

// File: tb/gpio_lat_port_tb_top.sv
`timescale 1ns/1ps
module gpio_lat_port_tb_top;

    typedef struct packed {
        logic [1:0] addr;
        logic [1:0] op;
        logic [2:0] bitn;
        logic [7:0] wdata;
        logic [7:0] pin;
        logic [7:0] exp_out;
        logic [7:0] exp_oe;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd1, 3'd0, 8'h00, 8'h00, 8'h00, 8'hFF, 4'd8},  // R8 all outputs
        '{2'd2, 2'd1, 3'd0, 8'hA5, 8'hA5, 8'hA5, 8'hFF, 4'd5},  // R5 alias byte write
        '{2'd2, 2'd2, 3'd1, 8'h00, 8'hA5, 8'hA7, 8'hFF, 4'd6},  // R6 alias set
        '{2'd2, 2'd3, 3'd7, 8'h00, 8'h00, 8'h27, 8'hFF, 4'd6},  // R6 alias clr, pads lag low
        '{2'd1, 2'd2, 3'd3, 8'h00, 8'h00, 8'h08, 8'hFF, 4'd7},  // R7 port set corrupts
        '{2'd1, 2'd1, 3'd0, 8'h3C, 8'h00, 8'h3C, 8'hFF, 4'd5},  // R5 port byte write
        '{2'd1, 2'd3, 3'd2, 8'h00, 8'h3C, 8'h38, 8'hFF, 4'd7},  // R7 port clr, pads agree
        '{2'd0, 2'd2, 3'd0, 8'h00, 8'h3C, 8'h38, 8'hFE, 4'd8},  // R8 dir set -> input
        '{2'd0, 2'd3, 3'd0, 8'h00, 8'h3C, 8'h38, 8'hFF, 4'd8},  // R8 dir clr -> output
        '{2'd3, 2'd1, 3'd0, 8'hFF, 8'h00, 8'h38, 8'hFF, 4'd9},  // R9 unused write
        '{2'd2, 2'd2, 3'd0, 8'h00, 8'h00, 8'h39, 8'hFF, 4'd6}   // R6 alias set, pads low
    };

    logic       clk = 0, rst = 1, bus_valid = 0;
    logic [1:0] bus_addr = 0, bus_op = 0;
    logic [2:0] bus_bit = 0;
    logic [7:0] bus_wdata = 0, pad_in = 0;
    logic [7:0] bus_rdata, pad_out, pad_oe;
    int n_checks = 0, n_fail = 0;

    always #2 clk = ~clk;

    gpio_lat_port dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_op(bus_op), .bus_bit(bus_bit), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] a, input logic [1:0] o,
                         input logic [2:0] b, input logic [7:0] d);
        bus_valid = 1; bus_addr = a; bus_op = o; bus_bit = b; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_op = 0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] v);
        bus_valid = 1; bus_addr = a; bus_op = 0;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pad_oe", pad_oe, 8'h00);
        do_read(2'd0, v); check("R1 dir read", v, 8'hFF);
        do_read(2'd2, v); check("R1 latch read", v, 8'h00);

        for (int i = 0; i < NV; i++) begin
            pad_in = VECS[i].pin;
            repeat (3) @(negedge clk);
            do_op(VECS[i].addr, VECS[i].op, VECS[i].bitn, VECS[i].wdata);
            check($sformatf("R%0d vec %0d pad_out", VECS[i].req, i), pad_out, VECS[i].exp_out);
            check($sformatf("R2 vec %0d pad_oe", i), pad_oe, VECS[i].exp_oe);
            do_read(2'd2, v);
            check($sformatf("R4 vec %0d latch view", i), v, VECS[i].exp_out);
        end

        // R3: two-edge synchronizer latency at the pin view
        bus_valid = 1; bus_addr = 2'd1; bus_op = 0;
        pad_in = 8'h5A;
        @(negedge clk); check("R3 after one edge", bus_rdata, 8'h00);
        @(negedge clk); check("R3 after two edges", bus_rdata, 8'h5A);
        bus_valid = 0;

        // R4: latch view ignores pads
        do_read(2'd2, v); check("R4 latch vs pads", v, 8'h39);
        // R9: unused address reads zero
        do_read(2'd3, v); check("R9 unused read", v, 8'h00);

        // R10: idle strobe ignores bus inputs
        bus_valid = 0; bus_addr = 2'd2; bus_op = 2'd1; bus_wdata = 8'hFF;
        @(negedge clk); @(negedge clk);
        bus_op = 0;
        check("R10 idle latch", pad_out, 8'h39);
        check("R10 idle dir", pad_oe, 8'hFF);

        // R7: port clear loads pad levels into the latch
        do_op(2'd1, 2'd3, 3'd0, 8'h00);
        check("R7 port clr", pad_out, 8'h5A);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule